// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block sits between a synchronous host and an asynchronous 256K x 4 DRAM that supports page mode. The host raises a single-cycle request carrying a write flag, an 18-bit word address and 4 bits of write data. The controller splits the address into a 9-bit row (upper half) and a 9-bit column (lower half). It presents them in turn on the nine shared address pins and sequences the row strobe, column strobe, write enable and output enable. Read data comes back on a one-cycle valid pulse.

Once a row is open it stays open. A later request to the same row costs only a column-strobe cycle. A request to a different row, or a row that has been open nearly as long as the DRAM allows, first closes the row and then waits out the precharge time. A separate refresh engine can ask for the DRAM pins. The controller then closes any open row, raises a grant, and takes no host request until the grant is released. Every strobe interval is a count of clock cycles, rounded up from nanosecond parameters.

The states are:
- ST_IDLE: no row open.
- ST_ROW: row address set up.
- ST_RAS: row strobe low, row address held.
- ST_COL: column address and write setup.
- ST_CAS: column strobe low.
- ST_CASHI: column precharge.
- ST_OPEN: row open, waiting.
- ST_CLOSE: row strobe held until its minimum width.
- ST_PRE: row precharge.
- ST_GRANT: pins handed to refresh.

The transitions are:
- IDLE goes to ROW on an accepted request, or to GRANT on a refresh request.
- ROW goes to RAS, RAS to COL, COL to CAS, CAS to CASHI, and CASHI to OPEN.
- OPEN goes to COL on a same-row request. It goes to CLOSE on a different-row request, a refresh request or the age limit.
- CLOSE goes to PRE.
- PRE goes to ROW when a request is pending, to GRANT when refresh is asked, and otherwise to IDLE.
- GRANT goes to PRE once the refresh request drops.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held, all four DRAM strobes are high (inactive), the data-pin enable is low, and host_busy, rd_valid and ref_gnt are low.
- R2: On each access, the row is host_addr[17:9]. It is on dram_addr when the row strobe falls. The column is host_addr[8:0]. It is on dram_addr when the column strobe falls.
- R3: A read returns the 4-bit value most recently written to the same host address, or 0 if the address was never written. Returns come in request order, each on a single-cycle rd_valid pulse. Data is sampled no earlier than 50 ns after the row strobe falls and no earlier than 15 ns after the column strobe falls.
- R4: A write is an early write. dram_we_n falls at least one cycle before the column strobe falls. dram_oe_n stays high, and dram_dq_oe is high with the write data while the column strobe is low.
- R5: The column strobe is low only while the row strobe is low. Consecutive column-strobe falls inside one row-strobe low period are at least 35 ns apart. A run of accesses to one row produces exactly one row-strobe fall.
- R6: After a row-strobe rise, the row strobe stays high at least 30 ns. Two row-strobe falls are at least 90 ns apart.
- R7: Each row-strobe low period lasts at least 50 ns.
- R8: No row-strobe low period exceeds 10 µs. An idle open row is closed on its own before that limit.
- R9: While ref_req is high, the controller closes any open row, then raises ref_gnt with all strobes high. host_busy stays high and no host request is accepted until ref_req falls.
- R10: A host request is accepted at a rising clock edge where host_req is high and host_busy is low. host_busy is high in the cycle after each acceptance.
- R11: The column address stays stable while the column strobe is low. dram_oe_n falls only when dram_we_n is high. dram_dq_oe is low during read column strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address: row in [17:9], column in [8:0] |
| host_wdata | input | 4 | Write data |
| host_busy | output | 1 | High when a request would not be accepted |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 4 | Read data |
| ref_req | input | 1 | Refresh engine asks for the DRAM pins |
| ref_gnt | output | 1 | Pins released to the refresh engine |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq_in | input | 4 | Data from the DRAM pins |
| dram_dq_out | output | 4 | Data to the DRAM pins |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |

## Verification
The assertions take three things for granted:
- ref_req is held high until ref_gnt has been seen and the refresh work is done.
- dram_dq_in is settled by the clock edge on which a read column cycle ends.
- Reset is held for several cycles.

The stimulus changes every input on the falling clock edge and keeps ref_req high across the whole grant. The DRAM model presents true data only once both access delays have passed at the next rising edge, and returns inverted data before that.

// File: rtl/fpm_ctrl_pkg.sv
`timescale 1ns/1ps
package fpm_ctrl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_RAS,
        ST_COL,
        ST_CAS,
        ST_CASHI,
        ST_OPEN,
        ST_CLOSE,
        ST_PRE,
        ST_GRANT
    } fpm_state_e;

    // Minimum interval in ns -> clock cycles, rounded up.
    function automatic int ns_to_cyc(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_hold_timer.sv
`timescale 1ns/1ps
module fpm_hold_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/fpm_row_age.sv
`timescale 1ns/1ps
module fpm_row_age #(
    parameter int AGE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_low,
    output logic [AGE_W-1:0] age
);
    // Cycles elapsed since the row strobe fell; saturates at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n || !row_low) begin
            age <= '0;
        end else if (age != '1) begin
            age <= age + 1'b1;
        end
    end
endmodule

// File: rtl/fpm_dram_ctrl.sv
`timescale 1ns/1ps
module fpm_dram_ctrl
    import fpm_ctrl_pkg::*;
#(
    parameter int PIN_W        = 9,
    parameter int DQ_W         = 4,
    parameter int CLK_NS       = 5,
    parameter int T_RC_NS      = 90,
    parameter int T_RAS_NS     = 50,
    parameter int T_RAS_MAX_NS = 10000,
    parameter int T_RP_NS      = 30,
    parameter int T_RAH_NS     = 10,
    parameter int T_RAC_NS     = 50,
    parameter int T_CAC_NS     = 15,
    parameter int T_CAS_NS     = 15,
    parameter int T_CP_NS      = 10,
    parameter int T_PC_NS      = 35
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [2*PIN_W-1:0] host_addr,
    input  logic [DQ_W-1:0]    host_wdata,
    output logic               host_busy,
    output logic               rd_valid,
    output logic [DQ_W-1:0]    rd_data,
    input  logic               ref_req,
    output logic               ref_gnt,
    output logic               dram_ras_n,
    output logic               dram_cas_n,
    output logic               dram_we_n,
    output logic               dram_oe_n,
    output logic [PIN_W-1:0]   dram_addr,
    input  logic [DQ_W-1:0]    dram_dq_in,
    output logic [DQ_W-1:0]    dram_dq_out,
    output logic               dram_dq_oe
);
    localparam int RAS_CYC     = ns_to_cyc(T_RAS_NS, CLK_NS);
    localparam int RC_CYC      = ns_to_cyc(T_RC_NS, CLK_NS);
    localparam int RP_CYC      = ns_to_cyc(T_RP_NS, CLK_NS);
    localparam int RAC_CYC     = imax(1, ns_to_cyc(T_RAC_NS, CLK_NS));
    localparam int RAH_CYC     = imax(1, ns_to_cyc(T_RAH_NS, CLK_NS));
    localparam int CP_CYC      = imax(1, ns_to_cyc(T_CP_NS, CLK_NS));
    localparam int CASW_CYC    = imax(imax(ns_to_cyc(T_CAS_NS, CLK_NS), ns_to_cyc(T_CAC_NS, CLK_NS)),
                                      imax(1, ns_to_cyc(T_PC_NS, CLK_NS) - CP_CYC - 1));
    localparam int PRE_CYC     = imax(RP_CYC, RC_CYC - RAS_CYC - 1);
    localparam int RAS_MAX_CYC = T_RAS_MAX_NS / CLK_NS;
    localparam int COL_LEN     = 1 + CASW_CYC + CP_CYC;
    localparam int OPEN_LIMIT  = RAS_MAX_CYC - COL_LEN - 4;
    localparam int AGE_W       = $clog2(RAS_MAX_CYC + 1) + 1;
    localparam int TMR_W       = $clog2(imax(imax(RAH_CYC, CASW_CYC), imax(CP_CYC, PRE_CYC)) + 1);

    localparam logic [AGE_W-1:0] AGE_RAS_OK = AGE_W'(RAS_CYC - 1);
    localparam logic [AGE_W-1:0] AGE_RAC_OK = AGE_W'(RAC_CYC - 1);
    localparam logic [AGE_W-1:0] AGE_LIMIT  = AGE_W'(OPEN_LIMIT);
    localparam logic [AGE_W-1:0] AGE_MAX    = AGE_W'(RAS_MAX_CYC);

    fpm_state_e           state, nstate;
    logic                 tmr_load, tmr_done;
    logic [TMR_W-1:0]     tmr_val;
    logic [AGE_W-1:0]     row_age;
    logic                 row_low;
    logic                 acc, hit, capture, pend;
    logic                 req_wr;
    logic [PIN_W-1:0]     req_row, req_col, open_row;
    logic [DQ_W-1:0]      req_data;

    fpm_hold_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    fpm_row_age #(.AGE_W(AGE_W)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .row_low (row_low),
        .age     (row_age)
    );

    assign host_busy = ref_req ||
                       !((state == ST_IDLE) || (state == ST_OPEN && row_age < AGE_LIMIT));
    assign acc       = host_req && !host_busy;
    assign hit       = (host_addr[2*PIN_W-1:PIN_W] == open_row);
    assign capture   = (state == ST_CAS) && (nstate == ST_CASHI) && !req_wr;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Next state and interval timer loads
    always_comb begin
        nstate   = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (ref_req)  nstate = ST_GRANT;
                else if (acc) nstate = ST_ROW;
            end
            ST_ROW: begin
                nstate   = ST_RAS;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(RAH_CYC - 1);
            end
            ST_RAS: begin
                if (tmr_done) nstate = ST_COL;
            end
            ST_COL: begin
                nstate   = ST_CAS;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(CASW_CYC - 1);
            end
            ST_CAS: begin
                if (tmr_done && (req_wr || row_age >= AGE_RAC_OK)) begin
                    nstate   = ST_CASHI;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(CP_CYC - 1);
                end
            end
            ST_CASHI: begin
                if (tmr_done) nstate = ST_OPEN;
            end
            ST_OPEN: begin
                if (ref_req || row_age >= AGE_LIMIT) nstate = ST_CLOSE;
                else if (acc)                        nstate = hit ? ST_COL : ST_CLOSE;
            end
            ST_CLOSE: begin
                if (row_age >= AGE_RAS_OK) begin
                    nstate   = ST_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(PRE_CYC - 1);
                end
            end
            ST_PRE: begin
                if (tmr_done) begin
                    if (pend)         nstate = ST_ROW;
                    else if (ref_req) nstate = ST_GRANT;
                    else              nstate = ST_IDLE;
                end
            end
            ST_GRANT: begin
                if (!ref_req) begin
                    nstate   = ST_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(PRE_CYC - 1);
                end
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // Request latch, open row and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_wr   <= 1'b0;
            req_row  <= '0;
            req_col  <= '0;
            req_data <= '0;
            open_row <= '0;
            pend     <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (acc) begin
                req_wr   <= host_we;
                req_row  <= host_addr[2*PIN_W-1:PIN_W];
                req_col  <= host_addr[PIN_W-1:0];
                req_data <= host_wdata;
            end
            if (state == ST_OPEN && acc && !hit && !ref_req) pend <= 1'b1;
            else if (state == ST_ROW)                          pend <= 1'b0;
            if (state == ST_ROW) open_row <= req_row;
            rd_valid <= capture;
            if (capture) rd_data <= dram_dq_in;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        row_low     = 1'b0;
        dram_cas_n  = 1'b1;
        dram_we_n   = 1'b1;
        dram_oe_n   = 1'b1;
        dram_dq_oe  = 1'b0;
        ref_gnt     = 1'b0;
        dram_addr   = req_col;
        dram_dq_out = req_data;
        unique case (state)
            ST_IDLE, ST_PRE: ;
            ST_ROW:   dram_addr = req_row;
            ST_RAS: begin
                row_low   = 1'b1;
                dram_addr = req_row;
            end
            ST_COL: begin
                row_low    = 1'b1;
                dram_we_n  = !req_wr;
                dram_dq_oe = req_wr;
            end
            ST_CAS: begin
                row_low    = 1'b1;
                dram_cas_n = 1'b0;
                dram_we_n  = !req_wr;
                dram_oe_n  = req_wr;
                dram_dq_oe = req_wr;
            end
            ST_CASHI, ST_OPEN, ST_CLOSE: row_low = 1'b1;
            ST_GRANT: ref_gnt = 1'b1;
            default: ;
        endcase
    end
    assign dram_ras_n = !row_low;

    a_r7_ras_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> ($past(row_age) >= AGE_RAS_OK));
    a_r8_ras_max_width: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> (row_age < AGE_MAX));
    a_r5_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);
    a_r11_col_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));
    a_r4_oe_only_reads: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_oe_n |-> (dram_we_n && !dram_dq_oe));
    a_r9_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> (dram_ras_n && dram_cas_n && host_busy));
    a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_busy) |=> host_busy);
endmodule

// File: tb/fpm_dram_ctrl_bench.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [17:0] host_addr = '0;
    logic [3:0]  host_wdata = '0;
    logic        host_busy, rd_valid, ref_gnt;
    logic [3:0]  rd_data;
    logic        ref_req = 1'b0;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [8:0]  dram_addr;
    logic [3:0]  dram_dq_in = '0;
    logic [3:0]  dram_dq_out;

    int checks = 0, failures = 0;

    bit   [3:0]  dmem [int];
    bit   [3:0]  shadow [int];
    logic [17:0] exp_addr_q [$];
    logic [3:0]  rd_q [$];

    real  t_rasf = 0.0, t_rasr = 0.0, t_casf = 0.0, t_wef = -1.0;
    bit   had_fall = 0, had_rise = 0, cas_in_row = 0;
    int   ras_falls = 0;
    logic [8:0] m_row = '0, m_col = '0, cas_addr = '0;

    always #2.5 clk = ~clk;

    fpm_dram_ctrl u_fpm_dram_ctrl (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_busy(host_busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_in(dram_dq_in),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input real act, input real exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0g expected=%0g", tag, what, act, exp);
        end
    endtask

    // DRAM model: read data for the next rising edge, true only after both access delays
    always @(negedge clk) begin
        real tn;
        bit [3:0] v;
        tn = $realtime + 2.5;
        if (!dram_ras_n && !dram_cas_n && !dram_oe_n && dram_we_n) begin
            v = dmem.exists(int'({m_row, m_col})) ? dmem[int'({m_row, m_col})] : 4'h0;
            dram_dq_in <= ((tn - t_rasf >= 50.0) && (tn - t_casf >= 15.0)) ? v : ~v;
        end else begin
            dram_dq_in <= 4'h0;
        end
    end

    always @(negedge dram_we_n) t_wef = $realtime;

    always @(negedge dram_ras_n) if (rst_n) begin
        ras_falls++;
        m_row = dram_addr;
        cas_in_row = 0;
        if (had_rise) chk($realtime - t_rasr >= 30.0, "R6", "row precharge ns", $realtime - t_rasr, 30.0);
        if (had_fall) chk($realtime - t_rasf >= 90.0, "R6", "row cycle ns", $realtime - t_rasf, 90.0);
        t_rasf = $realtime;
        had_fall = 1;
    end

    always @(posedge dram_ras_n) if (rst_n && had_fall) begin
        chk($realtime - t_rasf >= 50.0, "R7", "row low min ns", $realtime - t_rasf, 50.0);
        chk($realtime - t_rasf <= 10000.0, "R8", "row low max ns", $realtime - t_rasf, 10000.0);
        t_rasr = $realtime;
        had_rise = 1;
    end

    always @(negedge dram_cas_n) if (rst_n) begin
        logic [17:0] a;
        chk(!dram_ras_n, "R5", "column strobe with row low", dram_ras_n, 0);
        if (cas_in_row) chk($realtime - t_casf >= 35.0, "R5", "page cycle ns", $realtime - t_casf, 35.0);
        t_casf = $realtime;
        cas_in_row = 1;
        m_col = dram_addr;
        cas_addr = dram_addr;
        if (exp_addr_q.size() == 0) begin
            chk(0, "R2", "unexpected column cycle", 1, 0);
        end else begin
            a = exp_addr_q.pop_front();
            chk({m_row, m_col} == a, "R2", "row/col on pins", {m_row, m_col}, a);
        end
        if (!dram_we_n) begin
            chk(t_wef < $realtime, "R4", "write enable before column strobe", t_wef, $realtime);
            chk(dram_oe_n && dram_dq_oe, "R4", "oe high and dq driven", {dram_oe_n, dram_dq_oe}, 3);
            dmem[int'({m_row, m_col})] = dram_dq_out;
        end else begin
            chk(!dram_dq_oe, "R11", "dq not driven on read", dram_dq_oe, 0);
        end
    end

    always @(posedge dram_cas_n) if (rst_n && cas_in_row)
        chk(dram_addr == cas_addr, "R11", "column address held", dram_addr, cas_addr);

    always @(negedge dram_oe_n) if (rst_n)
        chk(dram_we_n, "R11", "oe only with we high", dram_we_n, 1);

    // Scoreboard monitor
    always @(negedge clk) if (rst_n && rd_valid) begin
        logic [3:0] e;
        if (rd_q.size() == 0) begin
            chk(0, "R3", "rd_valid with nothing pending", 1, 0);
        end else begin
            e = rd_q.pop_front();
            chk(rd_data == e, "R3", "read data", rd_data, e);
        end
    end

    task automatic note_accept(input bit w, input logic [17:0] a, input logic [3:0] d);
        exp_addr_q.push_back(a);
        if (w) shadow[int'(a)] = d;
        else   rd_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0);
    endtask

    task automatic do_acc(input bit w, input logic [17:0] a, input logic [3:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = w; host_addr = a; host_wdata = d;
        while (host_busy) @(negedge clk);
        note_accept(w, a, d);
        @(negedge clk);
        host_req = 1'b0;
        chk(host_busy, "R10", "busy after accept", host_busy, 1);
    endtask

    task automatic drain();
        int n = 0;
        while ((rd_q.size() != 0 || exp_addr_q.size() != 0) && n < 1000) begin
            @(negedge clk);
            n++;
        end
        repeat (20) @(negedge clk);
    endtask

    initial begin
        int f0;
        int n;
        bit ok;
        repeat (4) @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes high in reset",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        chk(!dram_dq_oe && !host_busy && !rd_valid && !ref_gnt, "R1", "flags low in reset",
            {dram_dq_oe, host_busy, rd_valid, ref_gnt}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R5: page hits on one row
        f0 = ras_falls;
        do_acc(1, {9'd5, 9'd3}, 4'h9);
        do_acc(1, {9'd5, 9'd4}, 4'h6);
        do_acc(0, {9'd5, 9'd3}, 4'h0);
        do_acc(0, {9'd5, 9'd4}, 4'h0);
        drain();
        chk(ras_falls - f0 == 1, "R5", "row opens once for hits", ras_falls - f0, 1);

        // R6: row misses
        f0 = ras_falls;
        do_acc(1, {9'd7, 9'd3}, 4'hC);
        do_acc(0, {9'd5, 9'd3}, 4'h0);
        do_acc(0, {9'd7, 9'd3}, 4'h0);
        drain();
        chk(ras_falls - f0 == 3, "R6", "one row open per miss", ras_falls - f0, 3);

        // R2: swapped row/column must not alias
        do_acc(1, {9'd3, 9'd200}, 4'h5);
        do_acc(0, {9'd200, 9'd3}, 4'h0);
        do_acc(0, {9'd3, 9'd200}, 4'h0);
        drain();

        // R9: refresh while a row is open
        do_acc(0, {9'd5, 9'd10}, 4'h0);
        drain();
        @(negedge clk);
        ref_req = 1'b1;
        n = 0;
        while (!ref_gnt && n < 100) begin @(negedge clk); n++; end
        chk(ref_gnt, "R9", "grant raised", ref_gnt, 1);
        chk(dram_ras_n && dram_cas_n, "R9", "strobes high under grant", {dram_ras_n, dram_cas_n}, 3);
        f0 = ras_falls;
        host_req = 1'b1; host_we = 1'b1; host_addr = {9'd6, 9'd1}; host_wdata = 4'h3;
        ok = 1;
        repeat (20) begin @(negedge clk); if (!host_busy) ok = 0; end
        chk(ok, "R9", "busy held under grant", ok, 1);
        chk(ras_falls == f0, "R9", "no host access under grant", ras_falls - f0, 0);
        ref_req = 1'b0;
        while (host_busy) @(negedge clk);
        note_accept(1, {9'd6, 9'd1}, 4'h3);
        @(negedge clk);
        host_req = 1'b0;
        do_acc(0, {9'd6, 9'd1}, 4'h0);
        drain();

        // R8: idle open row closes by itself
        do_acc(0, {9'd11, 9'd0}, 4'h0);
        drain();
        f0 = ras_falls;
        repeat (2100) @(negedge clk);
        chk(dram_ras_n, "R8", "idle row closed", dram_ras_n, 1);
        chk(ras_falls == f0, "R8", "no extra row open", ras_falls - f0, 0);

        // Mixed stream over three rows
        for (int i = 0; i < 24; i++) begin
            logic [17:0] a;
            a = {9'(5 + (i % 3) * 2), 9'((i * 37) % 512)};
            do_acc((i % 3) != 2, a, 4'(i + 1));
            if (i % 4 == 3) do_acc(0, a, 4'h0);
        end
        drain();
        chk(rd_q.size() == 0, "R3", "all reads returned", rd_q.size(), 0);
        chk(exp_addr_q.size() == 0, "R2", "all accesses issued", exp_addr_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R10", "watchdog expired", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule